// File: doc/BRIEF.md
# Reset-Qualified Memory Chip-Enable Gate

This block sits in the chip-enable path of a memory. It takes an active-low chip-enable from the system and passes it to the memory only while the system is out of reset. While the system is in reset the memory sees an inactive (high) enable, so a failing supply cannot cause stray writes.

Cutting an access off in its middle can corrupt the word being written. The block handles this case. If an access is already running on the clock edge where reset is first seen, the output enable stays active for a bounded grace window of `HOLD_CYCLES` clock cycles. The window ends early if the incoming enable releases. Once the window ends, the output stays inactive until reset clears. An access that begins while reset is asserted is never passed through.

All decisions are taken on the rising clock edge. The output is registered, so it follows its inputs one cycle later. The block's own flops have a synchronous active-low reset. The system reset being qualified is a separate, active-high input.

Top module: `ce_reset_gate`

## Requirements
- R1: While `rst_n` is low at a clock edge, `mem_ce_n` is high after that edge.
- R2: At an edge where `sys_reset` is low, `mem_ce_n` takes the value of `ce_in_n` sampled at that edge; the output lags its inputs by exactly one cycle.
- R3: The inactive level of `mem_ce_n` is high. With `sys_reset` high and no access in progress, `mem_ce_n` is high.
- R4: An access is in progress when `mem_ce_n` is low and `ce_in_n` is low at the edge where `sys_reset` is first seen high. In that case `mem_ce_n` stays low for `HOLD_CYCLES` cycles counted from that edge, and goes high on the `HOLD_CYCLES`-th edge after it.
- R5: If `ce_in_n` is high at any edge inside the grace window, `mem_ce_n` goes high after that edge. It stays high if `ce_in_n` falls again while `sys_reset` remains high.
- R6: A falling `ce_in_n` while `sys_reset` is high never drives `mem_ce_n` low. This includes a fall on the same edge where `sys_reset` is first seen.
- R7: Once the window has ended, `mem_ce_n` stays high for as long as `sys_reset` is high, whatever `ce_in_n` does. After `sys_reset` clears, R2 applies from the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the block's own flops |
| sys_reset | input | 1 | System reset state, high while the system is in reset |
| ce_in_n | input | 1 | Active-low chip-enable from the system |
| mem_ce_n | output | 1 | Active-low chip-enable to the memory, registered |

## Verification
The assertions assume that `sys_reset` and `ce_in_n` are synchronous to `clk` and stable around its rising edge. They also assume that `rst_n` is low from time zero until the first edges have passed. The stimulus changes inputs only on the falling clock edge and holds `rst_n` low for several cycles at the start. The assertions also take `HOLD_CYCLES` to be at least one. The bench therefore builds the gate with a small window of four cycles, so every count inside the window is exercised, and never uses zero.

// File: rtl/ce_gate_pkg.sv
// Package: shared types for the reset-qualified chip-enable gate.
// Assumes: nothing beyond standard SystemVerilog.
package ce_gate_pkg;

    // Operating phase of the gate controller.
    typedef enum logic [1:0] {
        GATE_OPEN  = 2'd0,  // system out of reset, enable passes through
        GATE_GRACE = 2'd1,  // reset seen mid-access, access allowed to finish
        GATE_BLOCK = 2'd2   // reset asserted, enable held inactive
    } gate_state_e;

endpackage

// File: rtl/ce_grace_timer.sv
// Module: ce_grace_timer
// Counts the cycles of the grace window. The controller loads it with
// 'start' on the edge where reset is first seen mid-access, and advances it
// with 'run' on each later edge of the window. 'expired' is high once
// HOLD_CYCLES cycles of the window have been counted.
// Assumes: HOLD_CYCLES >= 1; 'start' and 'run' never high together.
module ce_grace_timer #(
    parameter int HOLD_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

    logic [CW-1:0] cnt_q;

    // Load on window start, advance while the window is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= CW'(1);
        end else if (run) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expired = (cnt_q == LIMIT);

    // R4: the count never passes the window length.
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);

    // R4: the controller never advances a timer that has already expired.
    a_r4_no_run_past_limit: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> !expired);

    // R4: load and advance are exclusive.
    a_r4_start_run_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && run));

endmodule

// File: rtl/ce_gate_ctrl.sv
// Module: ce_gate_ctrl
// Decides each cycle whether the memory enable may be active. The decision
// depends on the system reset, the incoming enable, the registered output
// and the grace timer. It drives the timer controls and holds the output
// register.
// Assumes: inputs synchronous to clk; the timer reports 'expired' for the
// count it was loaded and advanced with.
module ce_gate_ctrl
    import ce_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sys_reset,
    input  logic ce_in_n,
    input  logic tmr_expired,
    output logic tmr_start,
    output logic tmr_run,
    output logic mem_ce_n
);
    gate_state_e state_q, state_d;
    logic        out_q, out_d;

    // Next phase, next output and timer controls.
    always_comb begin
        state_d   = state_q;
        out_d     = 1'b1;
        tmr_start = 1'b0;
        tmr_run   = 1'b0;
        unique case (state_q)
            GATE_OPEN: begin
                if (!sys_reset) begin
                    out_d = ce_in_n;
                end else if (!out_q && !ce_in_n) begin
                    state_d   = GATE_GRACE;
                    out_d     = 1'b0;
                    tmr_start = 1'b1;
                end else begin
                    state_d = GATE_BLOCK;
                end
            end
            GATE_GRACE: begin
                if (!sys_reset) begin
                    state_d = GATE_OPEN;
                    out_d   = ce_in_n;
                end else if (ce_in_n || tmr_expired) begin
                    state_d = GATE_BLOCK;
                end else begin
                    out_d   = 1'b0;
                    tmr_run = 1'b1;
                end
            end
            GATE_BLOCK: begin
                if (!sys_reset) begin
                    state_d = GATE_OPEN;
                    out_d   = ce_in_n;
                end
            end
            default: begin
                state_d = GATE_BLOCK;
            end
        endcase
    end

    // Phase and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GATE_OPEN;
            out_q   <= 1'b1;
        end else begin
            state_q <= state_d;
            out_q   <= out_d;
        end
    end

    assign mem_ce_n = out_q;

    // R1: the output leaves reset inactive.
    a_r1_reset_inactive: assert property (@(posedge clk)
        $past(!rst_n) |-> mem_ce_n);

    // R2: with the system out of reset the output follows the input a cycle later.
    a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sys_reset)) |-> (mem_ce_n == $past(ce_in_n)));

    // R3: an active output is always backed by an active input.
    a_r3_active_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> $past(!ce_in_n));

    // R5: a released input during reset deactivates the output.
    a_r5_release_ends: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sys_reset) && $past(ce_in_n)) |-> mem_ce_n);

    // R6: an output already inactive while in reset stays inactive.
    a_r6_no_new_access: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sys_reset) && $past(mem_ce_n)) |-> mem_ce_n);

    // R7: a blocked gate holds its output high.
    a_r7_block_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GATE_BLOCK) |-> mem_ce_n);

endmodule

// File: rtl/ce_reset_gate.sv
// Module: ce_reset_gate (top)
// Passes an active-low memory chip-enable only while the system is out of
// reset. An access running when reset is first seen may continue for up to
// HOLD_CYCLES cycles, or until its enable releases, whichever comes first.
// Assumes: HOLD_CYCLES >= 1; sys_reset and ce_in_n synchronous to clk.
module ce_reset_gate #(
    parameter int HOLD_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sys_reset,
    input  logic ce_in_n,
    output logic mem_ce_n
);
    localparam int RW = $clog2(HOLD_CYCLES + 3);

    logic tmr_start;
    logic tmr_run;
    logic tmr_expired;

    ce_gate_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sys_reset  (sys_reset),
        .ce_in_n    (ce_in_n),
        .tmr_expired(tmr_expired),
        .tmr_start  (tmr_start),
        .tmr_run    (tmr_run),
        .mem_ce_n   (mem_ce_n)
    );

    ce_grace_timer #(
        .HOLD_CYCLES(HOLD_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmr_start),
        .run    (tmr_run),
        .expired(tmr_expired)
    );

    // Port-level window monitor: counts consecutive edges that see reset high
    // while the output is active.
    logic [RW-1:0] win_run_q;

    // Count edges that see an active output under reset; clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_run_q <= '0;
        end else if (sys_reset && !mem_ce_n) begin
            if (win_run_q != {RW{1'b1}}) begin
                win_run_q <= win_run_q + RW'(1);
            end
        end else begin
            win_run_q <= '0;
        end
    end

    // R4: the output is active under reset for no more than the window allows
    // (the first edge that sees reset still shows the pre-reset output).
    a_r4_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
        win_run_q <= RW'(HOLD_CYCLES + 1));

endmodule

// File: tb/sim_ce_reset_gate.sv
`timescale 1ns/1ps
// Bench for ce_reset_gate: a vector table walked by one loop, then directed
// tests for a short reset pulse, a window restart and block reset mid-access.
module sim_ce_reset_gate;
    localparam int HOLD = 4;
    localparam int NV   = 26;

    // Each entry {sys_reset, ce_in_n, expected mem_ce_n}.
    localparam logic [2:0] VEC [NV] = '{
        3'b011, 3'b000, 3'b011, 3'b000,           // R2 pass-through
        3'b100, 3'b100, 3'b100, 3'b100, 3'b101,   // R4 full window, expiry
        3'b101, 3'b111, 3'b101, 3'b000,           // R7 hold, R6 new fall, release
        3'b000, 3'b100, 3'b100, 3'b111, 3'b101,   // R5 early release, re-fall
        3'b011, 3'b101, 3'b101, 3'b000, 3'b011,   // R6 fall at reset entry
        3'b111, 3'b111, 3'b011                    // R3 idle reset
    };
    localparam int VREQ [NV] = '{
        2, 2, 2, 2,
        4, 4, 4, 4, 4,
        7, 7, 6, 7,
        2, 4, 4, 5, 5,
        2, 6, 6, 2, 2,
        3, 3, 2
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sys_reset = 1'b0;
    logic ce_in_n = 1'b1;
    logic mem_ce_n;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    ce_reset_gate #(.HOLD_CYCLES(HOLD)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .sys_reset(sys_reset),
        .ce_in_n  (ce_in_n),
        .mem_ce_n (mem_ce_n)
    );

    // Compare the output with the expected value and log a failure.
    task automatic check(input int req, input logic exp);
        checks++;
        if (mem_ce_n !== exp) begin
            errors++;
            $display("FAIL R%0d: mem_ce_n got %b expected %b at %0t",
                     req, mem_ce_n, exp, $time);
        end
    endtask

    // Drive inputs at a falling edge and return at the next falling edge.
    task automatic step(input logic rst, input logic ce);
        sys_reset = rst;
        ce_in_n   = ce;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1, 1'b1);                       // R1 output inactive in reset
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][2], VEC[i][1]);
            check(VREQ[i], VEC[i][0]);
        end

        // R2: a reset pulse shorter than the window returns to pass-through.
        step(1'b0, 1'b0); check(2, 1'b0);
        step(1'b1, 1'b0); check(4, 1'b0);
        step(1'b0, 1'b0); check(2, 1'b0);

        // R4: a fresh reset during a live access restarts a full window.
        step(1'b1, 1'b0); check(4, 1'b0);
        for (int k = 1; k < HOLD; k++) begin
            step(1'b1, 1'b0); check(4, 1'b0);
        end
        step(1'b1, 1'b0); check(4, 1'b1);
        step(1'b1, 1'b0); check(7, 1'b1);
        step(1'b0, 1'b0); check(7, 1'b0);

        // R1: block reset during an active access forces the output high.
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 1'b1);
        rst_n = 1'b1;
        step(1'b0, 1'b0); check(2, 1'b0);

        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule